// File: doc/BRIEF.md
# Interleaved SAR Phase Sequencer

This block produces the digital timing for a converter built from many identical successive-approximation sections working side by side. A single free-running phase counter, clocked by the input clock, gives every section its own position in a frame that is as many clocks long as there are sections. Each section's frame lags the one before it by exactly one clock, so on every clock exactly one section takes an input sample while the others zero, calibrate, convert or hand over a result.

For each section the block drives six strobes: reference-zero sampling, offset (auto-zero) comparison, gain calibration comparison, input sampling, conversion window and result transfer. It also holds the successive-approximation register of every section. That register is stepped one bit per clock from a single comparator decision bit per section, and its value is presented as the trial code for that section's comparison level. A shared output selector then places the finished code of the section in its transfer cycle on one result bus, along with that section's index. The analog comparators, integrators and reference ladder are outside the block.

Top module: `ilv_sar_sequencer`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is low at a rising edge, the phase counter returns to the state in which section 0 is in frame cycle 1, and every section's trial code is cleared to 0. In this state `zero_smp` is `1<<0`, `in_smp` is `1<<13` and `xfer` is `1<<1` (default 16 sections).
- R2: Each section's schedule repeats every N_SECT (16) clocks, and in every clock each section asserts exactly one of its six strobes.
- R3: Within a section's frame, strobe order is fixed: cycle 1 `zero_smp`, cycle 2 `az_cmp`, cycle 3 `cal_cmp`, cycle 4 `in_smp`, cycles 5 to 15 `conv_act`, cycle 16 `xfer`. Bit s of each strobe vector belongs to section s.
- R4: Section s+1 runs the same schedule exactly one clock after section s, wrapping from the last section to section 0.
- R5: `in_smp` is one-hot on every clock after reset and is never all zero.
- R6: In frame cycle 5 a section's trial code (bits `trial_code[s*RES_BITS +: RES_BITS]`) is exactly the MSB alone (0x100 for 9 bits).
- R7: In frame cycles 5 to 13 one bit is tried per clock, MSB first. At the clock edge the bit under trial stays set if that section's `cmp_in` bit is 1 (input at or above the trial level) and is cleared if it is 0; the next lower bit is then set for the following trial.
- R8: In frame cycles 14 and 15 the trial code is held unchanged, so it equals the final converted code.
- R9: `out_sect` always names the section in frame cycle 16, and `out_data` carries that section's finished code; with an ideal comparator the code equals the floor of the input level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_in | input | N_SECT | Comparator decision per section, 1 = input at or above trial level |
| zero_smp | output | N_SECT | Reference-zero sampling strobe per section |
| az_cmp | output | N_SECT | Auto-zero comparison strobe per section |
| cal_cmp | output | N_SECT | Calibration comparison strobe per section |
| in_smp | output | N_SECT | Input sampling strobe per section, one-hot |
| conv_act | output | N_SECT | Conversion window strobe per section |
| xfer | output | N_SECT | Result transfer strobe per section, one-hot |
| trial_code | output | N_SECT*RES_BITS | Concatenated per-section SAR registers, section s at bits s*RES_BITS upward |
| out_data | output | RES_BITS | Finished code of the section in its transfer cycle |
| out_sect | output | $clog2(N_SECT) | Index of the section in its transfer cycle |

## Verification
Strobes and the output selector are combinational from the phase counter, so they are due in the same cycle the counter reaches a value, one edge after the previous one; the bench keeps its own cycle count from the reset release and derives every section's expected frame cycle from it. A trial code changes one edge after the decision it depends on, so the bench's comparator model updates `cmp_in` on the falling edge from the code then visible, and reads the code on the next falling edge. A finished conversion reaches `out_data` in frame cycle 16, twelve clocks after the sample cycle, so each stimulus round waits two full frames before its sixteen result checks. All outputs are sampled on falling edges, half a period away from any update.

// File: rtl/sps_pkg.sv
// Package: shared frame schedule for the interleaved SAR sequencer.
// Assumes the frame length equals the section count and the first four
// frame positions are the fixed zero / offset / gain / sample steps.
package sps_pkg;
    localparam int PH_ZERO   = 0;  // frame cycle 1
    localparam int PH_AZ     = 1;  // frame cycle 2
    localparam int PH_CAL    = 2;  // frame cycle 3
    localparam int PH_SAMPLE = 3;  // frame cycle 4
    localparam int PH_CONV0  = 4;  // frame cycle 5, first bit trial

    // Last frame position of a section, used for the transfer step.
    function automatic int last_phase(input int n_sect);
        return n_sect - 1;
    endfunction

    // Frame position of the last bit trial for a given resolution.
    function automatic int last_trial(input int res_bits);
        return PH_CONV0 + res_bits - 1;
    endfunction
endpackage

// File: rtl/sps_phase_counter.sv
// Module: shared phase counter. Counts 0..N_SECT-1 and wraps; value 0 means
// section 0 is in frame cycle 1. Assumes a synchronous active-low reset.
module sps_phase_counter #(
    parameter int N_SECT = 16,
    localparam int PW = $clog2(N_SECT)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] cnt
);
    localparam logic [PW-1:0] WRAP = PW'(N_SECT - 1);

    logic [PW-1:0] cnt_q;

    // Advance the frame position by one each clock, wrapping at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == WRAP)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

    // R2: the schedule advances by exactly one position per clock.
    assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) || (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/sps_section_timing.sv
// Module: per-section frame decoder. Derives one section's frame position
// from the shared counter (lagging by SECT clocks) and decodes the six
// strobes. Assumes N_SECT >= RES_BITS + 6 so the schedule fits one frame.
module sps_section_timing
    import sps_pkg::*;
#(
    parameter int N_SECT   = 16,
    parameter int RES_BITS = 9,
    parameter int SECT     = 0,
    localparam int PW = $clog2(N_SECT)
) (
    input  logic [PW-1:0] cnt,
    output logic [PW-1:0] phase,
    output logic          s_zero,
    output logic          s_az,
    output logic          s_cal,
    output logic          s_smp,
    output logic          s_conv,
    output logic          s_xfer
);
    localparam int XFER_PH = last_phase(N_SECT);

    // Position of this section in its own frame: counter minus section index.
    always_comb begin
        int p;
        p = (int'(cnt) + N_SECT - SECT) % N_SECT;
        phase = PW'(p);
    end

    // Decode the fixed schedule into strobes.
    always_comb begin
        s_zero = (int'(phase) == PH_ZERO);
        s_az   = (int'(phase) == PH_AZ);
        s_cal  = (int'(phase) == PH_CAL);
        s_smp  = (int'(phase) == PH_SAMPLE);
        s_conv = (int'(phase) >= PH_CONV0) && (int'(phase) < XFER_PH);
        s_xfer = (int'(phase) == XFER_PH);
    end
endmodule

// File: rtl/sps_sar_engine.sv
// Module: one section's successive-approximation register. Loads the MSB
// trial on the sample cycle, resolves one bit per clock MSB first, then holds.
// Assumes cmp is valid for the trial code shown in the same cycle.
module sps_sar_engine
    import sps_pkg::*;
#(
    parameter int N_SECT   = 16,
    parameter int RES_BITS = 9,
    localparam int PW = $clog2(N_SECT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PW-1:0]       phase,
    input  logic                cmp,
    output logic [RES_BITS-1:0] code
);
    localparam int TRIAL_END = last_trial(RES_BITS);
    localparam int XFER_PH   = last_phase(N_SECT);
    localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

    logic [RES_BITS-1:0] q;
    logic [RES_BITS-1:0] q_nxt;
    logic                armed_q;

    // Next register value: load MSB on sample, resolve during trials, else hold.
    always_comb begin
        int b;
        q_nxt = q;
        b = RES_BITS - 1 - (int'(phase) - PH_CONV0);
        if (int'(phase) == PH_SAMPLE) begin
            q_nxt = MSB_ONLY;
        end else if (int'(phase) >= PH_CONV0 && int'(phase) <= TRIAL_END) begin
            if (!cmp)
                q_nxt[b] = 1'b0;
            if (b > 0)
                q_nxt[b-1] = 1'b1;
        end
    end

    // Register update with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= q_nxt;
    end

    // Marks that a sample cycle has been seen since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (int'(phase) == PH_SAMPLE)
            armed_q <= 1'b1;
    end

    assign code = q;

    // R6: first trial of a conversion shows the MSB alone.
    assert_msb_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && int'(phase) == PH_CONV0) |-> (q == MSB_ONLY));

    // R8: the code is frozen through the two hold cycles and the transfer.
    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(phase) > TRIAL_END + 1 && int'(phase) <= XFER_PH) |-> (q == $past(q)));
endmodule

// File: rtl/sps_output_mux.sv
// Module: result selector. Picks the code of the section whose transfer
// strobe is high and encodes its index. Assumes xfer is one-hot.
module sps_output_mux #(
    parameter int N_SECT   = 16,
    parameter int RES_BITS = 9,
    localparam int PW = $clog2(N_SECT)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_SECT-1:0]            xfer,
    input  logic [N_SECT*RES_BITS-1:0]   codes,
    output logic [RES_BITS-1:0]          data,
    output logic [PW-1:0]                sect
);
    // OR together the masked codes and indices of the transferring section.
    always_comb begin
        data = '0;
        sect = '0;
        for (int s = 0; s < N_SECT; s++) begin
            if (xfer[s]) begin
                data = data | codes[s*RES_BITS +: RES_BITS];
                sect = sect | PW'(s);
            end
        end
    end

    // R9: exactly one section is in its transfer cycle at any time.
    assert_one_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(xfer));

    // R9: the named section advances by one each clock.
    assert_sect_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sect == $past(sect) + 1'b1));
endmodule

// File: rtl/ilv_sar_sequencer.sv
// Module: top of the interleaved SAR sequencer. One phase counter feeds
// N_SECT section decoders and SAR engines; an output selector forwards the
// result of the section in transfer. Assumes N_SECT is a power of two and
// N_SECT >= RES_BITS + 6.
module ilv_sar_sequencer #(
    parameter int N_SECT   = 16,
    parameter int RES_BITS = 9,
    localparam int PW = $clog2(N_SECT)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_SECT-1:0]           cmp_in,
    output logic [N_SECT-1:0]           zero_smp,
    output logic [N_SECT-1:0]           az_cmp,
    output logic [N_SECT-1:0]           cal_cmp,
    output logic [N_SECT-1:0]           in_smp,
    output logic [N_SECT-1:0]           conv_act,
    output logic [N_SECT-1:0]           xfer,
    output logic [N_SECT*RES_BITS-1:0]  trial_code,
    output logic [RES_BITS-1:0]         out_data,
    output logic [PW-1:0]               out_sect
);
    logic [PW-1:0] cnt;
    logic [PW-1:0] phase [N_SECT];

    sps_phase_counter #(.N_SECT(N_SECT)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt)
    );

    for (genvar s = 0; s < N_SECT; s++) begin : g_sect
        sps_section_timing #(
            .N_SECT(N_SECT), .RES_BITS(RES_BITS), .SECT(s)
        ) u_tim (
            .cnt    (cnt),
            .phase  (phase[s]),
            .s_zero (zero_smp[s]),
            .s_az   (az_cmp[s]),
            .s_cal  (cal_cmp[s]),
            .s_smp  (in_smp[s]),
            .s_conv (conv_act[s]),
            .s_xfer (xfer[s])
        );

        sps_sar_engine #(.N_SECT(N_SECT), .RES_BITS(RES_BITS)) u_sar (
            .clk   (clk),
            .rst_n (rst_n),
            .phase (phase[s]),
            .cmp   (cmp_in[s]),
            .code  (trial_code[s*RES_BITS +: RES_BITS])
        );
    end

    sps_output_mux #(.N_SECT(N_SECT), .RES_BITS(RES_BITS)) u_mux (
        .clk   (clk),
        .rst_n (rst_n),
        .xfer  (xfer),
        .codes (trial_code),
        .data  (out_data),
        .sect  (out_sect)
    );

    // R5: exactly one section samples the input on every clock.
    assert_one_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(in_smp));

    // R4: the sampling section moves up by one each clock (with wrap).
    assert_sample_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (in_smp == {$past(in_smp[N_SECT-2:0]), $past(in_smp[N_SECT-1])}));

    // R2: every section asserts exactly one strobe per clock.
    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(zero_smp | az_cmp | cal_cmp | in_smp | conv_act | xfer) == N_SECT);
endmodule

// File: tb/ilv_sar_sequencer_bench.sv
module ilv_sar_sequencer_bench;
    localparam int N  = 16;
    localparam int RB = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      cmp_in = '0;
    logic [N-1:0]      zero_smp, az_cmp, cal_cmp, in_smp, conv_act, xfer;
    logic [N*RB-1:0]   trial_code;
    logic [RB-1:0]     out_data;
    logic [3:0]        out_sect;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [RB-1:0] tgt [N];

    // Stimulus table: two rounds of per-section input levels; expected code = level.
    localparam logic [RB-1:0] VEC [32] = '{
        9'd0,   9'd511, 9'd256, 9'd255, 9'd1,   9'd510, 9'd170, 9'd341,
        9'd128, 9'd383, 9'd64,  9'd447, 9'd300, 9'd7,   9'd480, 9'd100,
        9'd33,  9'd66,  9'd99,  9'd132, 9'd165, 9'd198, 9'd231, 9'd264,
        9'd297, 9'd330, 9'd363, 9'd396, 9'd429, 9'd462, 9'd495, 9'd2
    };

    ilv_sar_sequencer #(.N_SECT(N), .RES_BITS(RB)) u_ilv_sar_sequencer (
        .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in),
        .zero_smp(zero_smp), .az_cmp(az_cmp), .cal_cmp(cal_cmp),
        .in_smp(in_smp), .conv_act(conv_act), .xfer(xfer),
        .trial_code(trial_code), .out_data(out_data), .out_sect(out_sect)
    );

    always #5 clk = ~clk;

    // Ideal comparator model: input at or above the trial level gives 1.
    always @(negedge clk) begin
        for (int s = 0; s < N; s++)
            cmp_in[s] <= (tgt[s] >= trial_code[s*RB +: RB]);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
    endtask

    function automatic int ph(input int s);
        return ((cyc % N) - s + N) % N;
    endfunction

    function automatic logic [RB-1:0] code_of(input int s);
        return trial_code[s*RB +: RB];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < N; s++) tgt[s] = VEC[s];
        do_reset();

        // R1: state straight after reset.
        check("R1 zero_smp", zero_smp, 32'h0001);
        check("R1 in_smp", in_smp, 32'h2000);
        check("R1 xfer", xfer, 32'h0002);
        check("R1 trial_code cleared", {31'd0, trial_code == '0}, 32'd1);

        // Table walk: each round settles two frames, then checks every transfer.
        for (int r = 0; r < 2; r++) begin
            for (int s = 0; s < N; s++) tgt[s] = VEC[r*N + s];
            repeat (2 * N) begin
                step();
                check("R5 in_smp one-hot", {31'd0, $onehot(in_smp)}, 32'd1);
            end
            repeat (N) begin
                step();
                check("R9 out_sect", out_sect, (cyc + 1) % N);
                check("R9 out_data", out_data, VEC[r*N + ((cyc + 1) % N)]);
            end
        end

        // R2 R3 R4: strobe order of section 5 and section 6 over two frames.
        while (ph(5) != 0) step();
        for (int k = 0; k < 2 * N; k++) begin
            int p5, p6;
            p5 = ph(5);
            p6 = ph(6);
            check("R3 zero sec5", zero_smp[5], p5 == 0);
            check("R3 az sec5",   az_cmp[5],   p5 == 1);
            check("R3 cal sec5",  cal_cmp[5],  p5 == 2);
            check("R3 smp sec5",  in_smp[5],   p5 == 3);
            check("R3 conv sec5", conv_act[5], p5 >= 4 && p5 <= 14);
            check("R3 xfer sec5", xfer[5],     p5 == 15);
            check("R4 smp sec6 lags", in_smp[6], p6 == 3);
            check("R2 one strobe sec6",
                  zero_smp[6] + az_cmp[6] + cal_cmp[6] + in_smp[6] + conv_act[6] + xfer[6], 1);
            step();
        end

        // R6 R7 R8: follow section 9 through a conversion of a known level.
        tgt[9] = 9'h0A5;
        repeat (N) step();
        while (ph(9) != 3) step();
        step();
        check("R6 msb trial", code_of(9), 9'h100);
        step();
        check("R7 bit8 cleared, bit7 set", code_of(9), 9'h080);
        step();
        check("R7 bit7 kept, bit6 set", code_of(9), 9'h0C0);
        while (ph(9) != 13) step();
        check("R8 hold cycle 14", code_of(9), 9'h0A5);
        step();
        check("R8 hold cycle 15", code_of(9), 9'h0A5);
        step();
        check("R9 transfer sec9", out_data, 9'h0A5);
        check("R9 transfer index", out_sect, 9);

        // R7: full-scale and zero levels on section 3.
        tgt[3] = 9'h1FF;
        repeat (N) step();
        while (ph(3) != 15) step();
        check("R7 full scale", out_data, 9'h1FF);
        tgt[3] = 9'h000;
        repeat (N) step();
        while (ph(3) != 15) step();
        check("R7 zero level", out_data, 9'h000);

        // R1: reset in mid-run returns the schedule and clears all codes.
        repeat (7) step();
        do_reset();
        check("R1 mid-run zero_smp", zero_smp, 32'h0001);
        check("R1 mid-run xfer", xfer, 32'h0002);
        check("R1 mid-run codes", {31'd0, trial_code == '0}, 32'd1);
        step();
        check("R4 after reset", in_smp, 32'h4000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule